// File: doc/BRIEF.md
# UART Baud Divisor Generator

This block converts the peripheral clock of a UART into a single-cycle tick at sixteen times the desired baud rate. The transmitter and receiver use that tick as their oversampling enable. Software programs the tick period through a small byte-wide register port that has an address, a write strobe, write data and combinational read data.

The divisor is 16 bits wide and is held in two byte registers. These share their offsets with other UART registers, so they are visible only while the divisor-access bit in the line-control byte is set. A divisor of N gives one tick every N peripheral clocks. A divisor of zero is treated as one.

The tick comes from a countdown state machine with three states:
- `CNT_LOAD` is the reset state. On the first clock after reset it loads the counter with the effective divisor minus one. It then moves to `CNT_RUN`, or straight to `CNT_WRAP` when that value is zero.
- `CNT_RUN` decrements the counter and moves to `CNT_WRAP` when the counter is 1.
- `CNT_WRAP` asserts the tick for one cycle and reloads the counter from the divisor present in that cycle. It then moves to `CNT_RUN`, or stays in `CNT_WRAP` when the effective divisor is one.

A divisor written during a countdown therefore takes effect only at the next reload.

Top module: `uart_baud_tick_gen`

## Requirements
- R1: During reset `baud_tick` is 0, the line-control byte reads 0x00 and the divisor is 0x0001. From the first clock after reset is released, `baud_tick` is high in every cycle until the divisor changes.
- R2: For an effective divisor N of 2 or more, `baud_tick` is a one-cycle pulse that repeats every N clocks.
- R3: A programmed divisor of 0x0000 gives the same tick pattern as 0x0001: `baud_tick` high in every cycle.
- R4: The divisor-access bit is bit 7 of the line-control byte at offset 3. While it is 1, a write to offset 0 sets divisor bits 7:0 and a write to offset 1 sets divisor bits 15:8. For example, bytes 0x05 and 0x01 give a period of 261 clocks.
- R5: While the divisor-access bit is 0, writes to offsets 0 and 1 leave the divisor and the tick period unchanged.
- R6: Offset 3 reads back all 8 bits of the line-control byte at all times. Offsets 0 and 1 read the divisor bytes while the access bit is 1 and read 0x00 while it is 0. Offset 2 reads 0x00.
- R7: A divisor written during a countdown does not shorten or extend that countdown. The new value sets the length of the interval that begins at the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register offset |
| we | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for the current `addr` (combinational) |
| baud_tick | output | 1 | Single-cycle tick at 16x the baud rate |

## Verification
The bench builds the block with its default parameters: two divisor bytes, a 2-bit offset and line control at offset 3. With these values the whole 16-bit divisor can be reached, including a high byte that is not zero (0x0105). The scoreboard compares every tick-to-tick interval against a queue of expected periods. This exposes off-by-one reload errors, a zero divisor that is not substituted, writes that leak through while the access bit is clear, and a reload that takes a new divisor in the middle of a countdown.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int BYTE_W       = 8;
    localparam int ACCESS_BIT   = 7;

    typedef enum logic [1:0] {
        CNT_LOAD = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_WRAP = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/baud_regfile.sv
module baud_regfile
    import baud_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DIV_BYTES = 2,
    parameter int CTRL_OFS  = 3,
    localparam int DIV_W    = BYTE_W * DIV_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [DIV_W-1:0]  divisor
);

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] div_bytes [DIV_BYTES];
    logic              access_en;

    assign access_en = ctrl_q[ACCESS_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (we && addr == ADDR_W'(CTRL_OFS)) begin
            ctrl_q <= wdata;
        end
    end

    for (genvar g = 0; g < DIV_BYTES; g++) begin : g_div_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                div_bytes[g] <= (g == 0) ? BYTE_W'(1) : '0;
            end else if (we && access_en && addr == ADDR_W'(g)) begin
                div_bytes[g] <= wdata;
            end
        end
        assign divisor[g*BYTE_W +: BYTE_W] = div_bytes[g];

        // R4: an enabled write lands in the addressed divisor byte
        a_r4_byte_write: assert property (@(posedge clk) disable iff (rst)
            (we && access_en && addr == ADDR_W'(g)) |=> div_bytes[g] == $past(wdata));
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_OFS)) begin
            rdata = ctrl_q;
        end else begin
            for (int i = 0; i < DIV_BYTES; i++) begin
                if (access_en && addr == ADDR_W'(i)) begin
                    rdata = div_bytes[i];
                end
            end
        end
    end

    // R5: with the access bit clear, divisor-offset writes change nothing
    a_r5_locked: assert property (@(posedge clk) disable iff (rst)
        (we && !access_en && addr != ADDR_W'(CTRL_OFS)) |=> $stable(divisor));

endmodule

// File: rtl/baud_countdown.sv
module baud_countdown
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    cnt_state_e       st_q, st_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] reload;

    // zero is treated as one, so the reload value saturates at zero
    assign reload = (div_i == '0) ? '0 : div_i - DIV_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CNT_LOAD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            CNT_LOAD, CNT_WRAP: begin
                cnt_d = reload;
                st_d  = (reload == '0) ? CNT_WRAP : CNT_RUN;
            end
            CNT_RUN: begin
                cnt_d = cnt_q - DIV_W'(1);
                st_d  = (cnt_q == DIV_W'(1)) ? CNT_WRAP : CNT_RUN;
            end
            default: begin
                cnt_d = '0;
                st_d  = CNT_LOAD;
            end
        endcase
    end

    always_comb begin
        tick_o = (st_q == CNT_WRAP);
    end

    // R2: a tick with a divisor above one is followed by a quiet cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i > DIV_W'(1)) |=> !tick_o);

    // R3: divisor zero or one keeps the tick asserted
    a_r3_zero_as_one: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i <= DIV_W'(1)) |=> tick_o);

    // R7: a divisor change mid-countdown cannot fire an early tick
    a_r7_no_cut_short: assert property (@(posedge clk) disable iff (rst)
        (st_q == CNT_RUN && cnt_q > DIV_W'(1) && !$stable(div_i)) |=> !tick_o);

endmodule

// File: rtl/uart_baud_tick_gen.sv
module uart_baud_tick_gen
    import baud_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DIV_BYTES = 2,
    parameter int CTRL_OFS  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              baud_tick
);

    localparam int DIV_W = BYTE_W * DIV_BYTES;

    logic [DIV_W-1:0] divisor;

    baud_regfile #(
        .ADDR_W    (ADDR_W),
        .DIV_BYTES (DIV_BYTES),
        .CTRL_OFS  (CTRL_OFS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .we      (we),
        .wdata   (wdata),
        .rdata   (rdata),
        .divisor (divisor)
    );

    baud_countdown #(
        .DIV_W (DIV_W)
    ) u_count (
        .clk    (clk),
        .rst    (rst),
        .div_i  (divisor),
        .tick_o (baud_tick)
    );

    // R1: no tick while reset is held
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (rst || baud_tick || !baud_tick) && (!rst || !baud_tick));

endmodule

// File: tb/uart_baud_tick_gen_tb.sv
`timescale 1ns/1ps
module uart_baud_tick_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       baud_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int prev_cyc = 0;
    bit have_prev = 0;

    typedef struct { int n; string req; } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    uart_baud_tick_gen u_dut (
        .clk(clk), .rst(rst), .addr(addr), .we(we),
        .wdata(wdata), .rdata(rdata), .baud_tick(baud_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(rdata === exp, req, rdata, exp);
    endtask

    task automatic program_div(input logic [15:0] d, input logic [7:0] ctrl_after);
        wr(2'd3, 8'h80);
        wr(2'd0, d[7:0]);
        wr(2'd1, d[15:8]);
        wr(2'd3, ctrl_after);
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!baud_tick);
    endtask

    // Driver side of the scoreboard: sync to a tick, then queue periods
    task automatic expect_periods(input int n, input int count, input string req);
        wait_tick();
        @(posedge clk);
        for (int i = 0; i < count; i++) q.push_back('{n: n, req: req});
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    // Monitor: measure tick-to-tick intervals and compare with the queue
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst && baud_tick) begin
                if (have_prev && q.size() != 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc - prev_cyc == e.n, e.req, cyc - prev_cyc, e.n);
                end
                prev_cyc = cyc;
                have_prev = 1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (R1..R7 run): actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(baud_tick === 1'b0, "R1 tick in reset", baud_tick, 0);
        addr = 2'd3; #1;
        check(rdata === 8'h00, "R1 ctrl reset", rdata, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(baud_tick === 1'b1, "R1 first tick", baud_tick, 1);
        expect_periods(1, 4, "R1 default period");
        drain();
        rd_check(2'd0, 8'h00, "R6 low hidden");
        rd_check(2'd1, 8'h00, "R6 high hidden");
        rd_check(2'd2, 8'h00, "R6 offset2");
        wr(2'd3, 8'h80);
        rd_check(2'd0, 8'h01, "R1 reset low byte");
        rd_check(2'd1, 8'h00, "R1 reset high byte");
        rd_check(2'd3, 8'h80, "R6 ctrl readback");

        // R2: period 5
        program_div(16'd5, 8'h03);
        rd_check(2'd3, 8'h03, "R6 ctrl all bits");
        expect_periods(5, 4, "R2 period 5");
        drain();

        // R3: zero acts as one
        program_div(16'd0, 8'h00);
        expect_periods(1, 4, "R3 zero as one");
        drain();

        // R4: high byte used
        program_div(16'h0105, 8'h00);
        expect_periods(261, 2, "R4 high byte period");
        drain();

        // R5: locked writes ignored
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h00);
        rd_check(2'd1, 8'h00, "R6 high hidden after write");
        expect_periods(261, 2, "R5 locked period");
        drain();
        wr(2'd3, 8'h80);
        rd_check(2'd0, 8'h05, "R5 low kept");
        rd_check(2'd1, 8'h01, "R5 high kept");
        wr(2'd3, 8'h00);

        // R7: mid-countdown change
        program_div(16'd40, 8'h00);
        expect_periods(40, 1, "R7 old period kept");
        repeat (3) @(negedge clk);
        program_div(16'd3, 8'h00);
        for (int i = 0; i < 3; i++) q.push_back('{n: 3, req: "R7 new period"});
        drain();

        // R2: period 2, single-cycle pulses
        program_div(16'd2, 8'h00);
        expect_periods(2, 5, "R2 period 2");
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule